// File: doc/BRIEF.md
# Memory Self-Test Failure Datalog Unloader

This block works next to a memory self-test engine and manages how failure information leaves the chip. The engine issues test operations only while the block grants permission (`eng_go`). It reports each miscompare with a one-cycle strobe, together with the pattern step, the failing address and the failing bit index.

In bitmap mode the first miscompare does three things. It stops the engine, captures a 32-bit datalog word and raises a fail flag on the result bus. The block then waits for as long as needed, so that outside logic can slow the clock. When the outside logic raises a shift request, the block sends the datalog out least significant bit first, one bit per shift-enable cycle. When the outside logic drops the request, testing resumes.

In accumulate mode a miscompare does not pause testing. The block keeps the first datalog, and any later failure only advances the overflow counter. When the engine reports that it has finished, the run indicator falls and the result bus shows a fixed end-of-test code. The retained datalog can then be unloaded serially with the same request and enable handshake.

Top module: `mbist_dlog_unloader`

## Requirements
- R1: Synchronous active-high `rst` gives `run`=0, `eng_go`=0, `result`=3'b000 and `ovf_cnt`=0 on the cycle after the reset edge.
- R2: In idle or end-of-test, `test_start` starts a test: one cycle later `run`=1 and `eng_go`=1, and the fail flag and `ovf_cnt` are cleared.
- R3: In bitmap mode (`bitmap_mode`=1), a `miscmp` sampled while testing captures the datalog {step[7:0], address[15:0], bit index[7:0]}. One cycle later `eng_go`=0 and the fail flag `result[1]`=1.
- R4: After a bitmap failure, `eng_go` stays 0 and `result[1]` stays 1 for any number of cycles until `shift_req` is raised.
- R5: The clock edge that samples `shift_req`=1 loads the datalog, and datalog bit 0 then appears on `result[0]`. Each later edge with `shift_en`=1 moves `result[0]` on to the next higher bit.
- R6: After 32 shifts `result[0]` is 0, and further `shift_en` cycles emit no more bits.
- R7: Dropping `shift_req` after a bitmap unload gives `eng_go`=1 and `result[1]`=0 one cycle later, so testing resumes.
- R8: A `miscmp` while a datalog is held adds one to `ovf_cnt`, which saturates at its maximum. The held datalog is not changed.
- R9: In accumulate mode (`bitmap_mode`=0), a miscompare leaves `eng_go` at 1. The first datalog is kept, and each later failure only adds to `ovf_cnt`.
- R10: When `eng_done`=1 during testing, one cycle later `run`=0, `eng_go`=0 and `result[2:1]`=2'b11. A `shift_req` then unloads the retained datalog LSB first, as in R5.
- R11: `run` stays 1 while testing is paused for a datalog.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bitmap_mode | input | 1 | 1: pause on each failure; 0: accumulate |
| test_start | input | 1 | Begin a test sequence |
| eng_done | input | 1 | Engine has no operations left |
| miscmp | input | 1 | Miscompare strobe from the engine |
| miscmp_step | input | STEP_W | Pattern step of the failure |
| miscmp_addr | input | ADDR_W | Failing address |
| miscmp_bit | input | BIT_W | Failing bit index |
| shift_req | input | 1 | External datalog unload request |
| shift_en | input | 1 | Slow shift enable, one bit per cycle |
| eng_go | output | 1 | Engine may issue the next operation |
| run | output | 1 | Test sequence in progress |
| result | output | 3 | [2] end-of-test, [1] fail flag, [0] serial datalog |
| ovf_cnt | output | OVF_W | Saturating count of unrecorded failures |

## Verification
The bench holds the pause for gaps from zero to two hundred cycles. A design that does not wait indefinitely would restart the engine or drop the flag before the unload. It also holds the request after all 32 bits have gone and sends extra shift enables; a shifter that wraps or does not stop would show stale bits. Bursts of failures during a pause check that the overflow counter saturates and that the held word is not overwritten. Accumulate mode and end-of-test unloading check that the retained word, not the latest one, comes out under the fixed status code.

// File: rtl/mbist_dlog_pkg.sv
package mbist_dlog_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_RUN       = 3'd1,
    ST_PAUSE     = 3'd2,
    ST_SHIFT     = 3'd3,
    ST_EOT       = 3'd4,
    ST_EOT_SHIFT = 3'd5
  } ctrl_state_t;

endpackage

// File: rtl/dlog_capture.sv
module dlog_capture #(
  parameter int STEP_W = 8,
  parameter int ADDR_W = 16,
  parameter int BIT_W  = 8,
  parameter int OVF_W  = 4,
  localparam int DW    = STEP_W + ADDR_W + BIT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              capture,
  input  logic              ovf_hit,
  input  logic [STEP_W-1:0] step,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BIT_W-1:0]  bitidx,
  output logic [DW-1:0]     dlog,
  output logic [OVF_W-1:0]  ovf_cnt
);

  localparam logic [OVF_W-1:0] OVF_MAX = '1;

  // datalog word: pattern step on top, failing bit index at the bottom
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      dlog <= '0;
    end else if (capture) begin
      dlog <= {step, addr, bitidx};
    end
  end

  // saturating count of failures that found the datalog already occupied
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      ovf_cnt <= '0;
    end else if (ovf_hit && ovf_cnt != OVF_MAX) begin
      ovf_cnt <= ovf_cnt + 1'b1;
    end
  end

  AST_DLOG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ovf_hit && !capture && !clear) |=> $stable(dlog)); // R8
  AST_OVF_SAT: assert property (@(posedge clk) disable iff (rst)
    (ovf_cnt == OVF_MAX && !clear) |=> (ovf_cnt == OVF_MAX)); // R8

endmodule

// File: rtl/dlog_shifter.sv
module dlog_shifter #(
  parameter int W     = 32,
  localparam int CW   = $clog2(W + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         en,
  input  logic [W-1:0] din,
  output logic         sbit
);

  localparam logic [CW-1:0] FULL = CW'(W);

  logic [W-1:0]  sr;
  logic [CW-1:0] cnt;

  // cnt == W marks an exhausted shifter; reset leaves it exhausted
  always_ff @(posedge clk) begin
    if (rst) begin
      sr  <= '0;
      cnt <= FULL;
    end else if (load) begin
      sr  <= din;
      cnt <= '0;
    end else if (en && cnt != FULL) begin
      sr  <= {1'b0, sr[W-1:1]};
      cnt <= cnt + 1'b1;
    end
  end

  assign sbit = (cnt != FULL) ? sr[0] : 1'b0;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULL); // R6
  AST_NO_EXTRA: assert property (@(posedge clk) disable iff (rst)
    (en && !load && cnt == FULL) |=> (cnt == FULL && !sbit)); // R6

endmodule

// File: rtl/dlog_unload_ctrl.sv
module dlog_unload_ctrl
  import mbist_dlog_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bitmap_mode,
  input  logic test_start,
  input  logic eng_done,
  input  logic miscmp,
  input  logic shift_req,
  output logic capture,
  output logic ovf_hit,
  output logic clear,
  output logic load,
  output logic act,
  output logic eng_go,
  output logic run,
  output logic fail,
  output logic eot
);

  ctrl_state_t state, nxt;
  logic        fail_d;
  logic        start_ok;
  logic        holding;

  assign start_ok = test_start && (state == ST_IDLE || state == ST_EOT);
  assign holding  = (state == ST_RUN) || (state == ST_PAUSE) || (state == ST_SHIFT);
  assign capture  = (state == ST_RUN) && miscmp && !fail;
  assign ovf_hit  = miscmp && fail && holding;
  assign clear    = start_ok;
  assign load     = shift_req && !start_ok && (state == ST_PAUSE || state == ST_EOT);

  always_comb begin
    nxt    = state;
    fail_d = fail;
    unique case (state)
      ST_IDLE: begin
        if (test_start) begin
          nxt    = ST_RUN;
          fail_d = 1'b0;
        end
      end
      ST_RUN: begin
        if (capture) fail_d = 1'b1;
        if (capture && bitmap_mode) nxt = ST_PAUSE;
        else if (eng_done)          nxt = ST_EOT;
      end
      ST_PAUSE: begin
        if (shift_req) nxt = ST_SHIFT;
      end
      ST_SHIFT: begin
        if (!shift_req) begin
          nxt    = ST_RUN;
          fail_d = 1'b0;
        end
      end
      ST_EOT: begin
        if (test_start) begin
          nxt    = ST_RUN;
          fail_d = 1'b0;
        end else if (shift_req) begin
          nxt = ST_EOT_SHIFT;
        end
      end
      ST_EOT_SHIFT: begin
        if (!shift_req) nxt = ST_EOT;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  // all status outputs registered from the next state
  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      fail   <= 1'b0;
      eng_go <= 1'b0;
      run    <= 1'b0;
      eot    <= 1'b0;
      act    <= 1'b0;
    end else begin
      state  <= nxt;
      fail   <= fail_d;
      eng_go <= (nxt == ST_RUN);
      run    <= (nxt == ST_RUN) || (nxt == ST_PAUSE) || (nxt == ST_SHIFT);
      eot    <= (nxt == ST_EOT) || (nxt == ST_EOT_SHIFT);
      act    <= (nxt == ST_SHIFT) || (nxt == ST_EOT_SHIFT);
    end
  end

  AST_PAUSE_ON_FAIL: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && bitmap_mode && miscmp && !fail) |=> (fail && !eng_go)); // R3
  AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PAUSE && !shift_req) |=> (state == ST_PAUSE && fail && !eng_go)); // R4
  AST_RESUME: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SHIFT && !shift_req) |=> (eng_go && !fail)); // R7
  AST_RUN_IN_PAUSE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PAUSE || state == ST_SHIFT) |-> run); // R11
  AST_EOT_CODE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && eng_done && !capture) |=> (eot && !run && !eng_go)); // R10

endmodule

// File: rtl/mbist_dlog_unloader.sv
module mbist_dlog_unloader #(
  parameter int STEP_W = 8,
  parameter int ADDR_W = 16,
  parameter int BIT_W  = 8,
  parameter int OVF_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bitmap_mode,
  input  logic              test_start,
  input  logic              eng_done,
  input  logic              miscmp,
  input  logic [STEP_W-1:0] miscmp_step,
  input  logic [ADDR_W-1:0] miscmp_addr,
  input  logic [BIT_W-1:0]  miscmp_bit,
  input  logic              shift_req,
  input  logic              shift_en,
  output logic              eng_go,
  output logic              run,
  output logic [2:0]        result,
  output logic [OVF_W-1:0]  ovf_cnt
);

  localparam int DW = STEP_W + ADDR_W + BIT_W;

  logic          capture, ovf_hit, clear, load, act, fail, eot;
  logic [DW-1:0] dlog;
  logic          sbit;

  dlog_unload_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .bitmap_mode (bitmap_mode),
    .test_start  (test_start),
    .eng_done    (eng_done),
    .miscmp      (miscmp),
    .shift_req   (shift_req),
    .capture     (capture),
    .ovf_hit     (ovf_hit),
    .clear       (clear),
    .load        (load),
    .act         (act),
    .eng_go      (eng_go),
    .run         (run),
    .fail        (fail),
    .eot         (eot)
  );

  dlog_capture #(
    .STEP_W (STEP_W),
    .ADDR_W (ADDR_W),
    .BIT_W  (BIT_W),
    .OVF_W  (OVF_W)
  ) u_cap (
    .clk     (clk),
    .rst     (rst),
    .clear   (clear),
    .capture (capture),
    .ovf_hit (ovf_hit),
    .step    (miscmp_step),
    .addr    (miscmp_addr),
    .bitidx  (miscmp_bit),
    .dlog    (dlog),
    .ovf_cnt (ovf_cnt)
  );

  dlog_shifter #(
    .W (DW)
  ) u_shift (
    .clk  (clk),
    .rst  (rst),
    .load (load),
    .en   (shift_en && act),
    .din  (dlog),
    .sbit (sbit)
  );

  assign result = {eot, eot | fail, act & sbit};

endmodule

// File: tb/tb_mbist_dlog_unloader.sv
`timescale 1ns/1ps
module tb_mbist_dlog_unloader;

  logic        clk = 1'b0;
  logic        rst, bitmap_mode, test_start, eng_done, miscmp, shift_req, shift_en;
  logic [7:0]  miscmp_step, miscmp_bit;
  logic [15:0] miscmp_addr;
  logic        eng_go, run;
  logic [2:0]  result;
  logic [3:0]  ovf_cnt;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  mbist_dlog_unloader dut (
    .clk (clk), .rst (rst), .bitmap_mode (bitmap_mode), .test_start (test_start),
    .eng_done (eng_done), .miscmp (miscmp), .miscmp_step (miscmp_step),
    .miscmp_addr (miscmp_addr), .miscmp_bit (miscmp_bit), .shift_req (shift_req),
    .shift_en (shift_en), .eng_go (eng_go), .run (run), .result (result),
    .ovf_cnt (ovf_cnt)
  );

  // {step, address, bit index, pause gap in cycles}
  localparam logic [39:0] VEC [0:3] = '{
    40'h01_0000_00_00,
    40'hA5_FFFF_1F_03,
    40'h3C_1234_80_28,
    40'hFF_8001_07_C8
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic fail_evt(logic [31:0] w);
    miscmp      = 1'b1;
    miscmp_step = w[31:24];
    miscmp_addr = w[23:8];
    miscmp_bit  = w[7:0];
    tick();
    miscmp      = 1'b0;
  endtask

  task automatic unload(logic [31:0] w, string req);
    shift_req = 1'b1;
    tick();
    for (int k = 0; k < 32; k++) begin
      check(req, "serial bit", {31'b0, result[0]}, {31'b0, w[k]});
      shift_en = 1'b1;
      tick();
      shift_en = 1'b0;
      if (k % 5 == 0) tick();
    end
    check("R6", "line after last bit", {31'b0, result[0]}, 32'h0);
    shift_en = 1'b1;
    repeat (3) tick();
    shift_en = 1'b0;
    check("R6", "no extra bits", {31'b0, result[0]}, 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] w, first;
    rst = 1'b1; bitmap_mode = 1'b1; test_start = 1'b0; eng_done = 1'b0;
    miscmp = 1'b0; shift_req = 1'b0; shift_en = 1'b0;
    miscmp_step = '0; miscmp_addr = '0; miscmp_bit = '0;
    repeat (3) tick();
    rst = 1'b0;
    check("R1", "run", {31'b0, run}, 0);
    check("R1", "eng_go", {31'b0, eng_go}, 0);
    check("R1", "result", {29'b0, result}, 0);
    check("R1", "ovf", {28'b0, ovf_cnt}, 0);

    test_start = 1'b1; tick(); test_start = 1'b0;
    check("R2", "run", {31'b0, run}, 1);
    check("R2", "eng_go", {31'b0, eng_go}, 1);

    // table walk: bitmap failures with varied pause gaps
    for (int i = 0; i < 4; i++) begin
      w = VEC[i][39:8];
      fail_evt(w);
      check("R3", "eng_go paused", {31'b0, eng_go}, 0);
      check("R3", "fail flag", {31'b0, result[1]}, 1);
      check("R11", "run in pause", {31'b0, run}, 1);
      repeat (int'(VEC[i][7:0])) tick();
      check("R4", "still paused", {31'b0, eng_go}, 0);
      check("R4", "flag held", {31'b0, result[1]}, 1);
      unload(w, "R5");
      check("R11", "run while shifting", {31'b0, run}, 1);
      shift_req = 1'b0; tick();
      check("R7", "resumed", {31'b0, eng_go}, 1);
      check("R7", "flag cleared", {31'b0, result[1]}, 0);
    end

    // failures during a pause: overflow and hold
    first = 32'hC3_5AA5_42;
    fail_evt(first);
    miscmp = 1'b1;
    for (int j = 0; j < 17; j++) begin
      miscmp_step = 8'(j); miscmp_addr = 16'(j * 7); miscmp_bit = 8'(j + 1);
      tick();
      if (j == 2) check("R8", "ovf count", {28'b0, ovf_cnt}, 3);
    end
    miscmp = 1'b0;
    check("R8", "ovf saturated", {28'b0, ovf_cnt}, 15);
    unload(first, "R8");
    shift_req = 1'b0; tick();
    check("R7", "resumed after overflow", {31'b0, eng_go}, 1);

    // end of test
    eng_done = 1'b1; tick();
    check("R10", "run low", {31'b0, run}, 0);
    check("R10", "eng_go low", {31'b0, eng_go}, 0);
    check("R10", "status code", {30'b0, result[2:1]}, 2'b11);
    unload(first, "R10");
    shift_req = 1'b0; tick();
    check("R10", "code kept", {30'b0, result[2:1]}, 2'b11);

    // accumulate mode
    eng_done = 1'b0; bitmap_mode = 1'b0;
    test_start = 1'b1; tick(); test_start = 1'b0;
    check("R2", "ovf cleared", {28'b0, ovf_cnt}, 0);
    check("R2", "result cleared", {29'b0, result}, 0);
    w = 32'h11_2233_44;
    fail_evt(w);
    check("R9", "no pause", {31'b0, eng_go}, 1);
    check("R9", "flag", {31'b0, result[1]}, 1);
    fail_evt(32'h99_8877_66);
    check("R9", "second counted", {28'b0, ovf_cnt}, 1);
    check("R9", "still going", {31'b0, eng_go}, 1);
    eng_done = 1'b1; tick();
    unload(w, "R9");
    shift_req = 1'b0; eng_done = 1'b0; tick();

    // reset in the middle of a pause
    bitmap_mode = 1'b1;
    test_start = 1'b1; tick(); test_start = 1'b0;
    fail_evt(32'hDE_ADBE_EF);
    rst = 1'b1; tick(); rst = 1'b0;
    check("R1", "run after reset", {31'b0, run}, 0);
    check("R1", "result after reset", {29'b0, result}, 0);
    check("R1", "eng_go after reset", {31'b0, eng_go}, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule